// File: doc/BRIEF.md
# Oscillator Steering Loop Filter

This block turns one signed timing error per measurement epoch into a signed control word for a digitally tuned oscillator. It applies a proportional term, a saturating integral term and, in the precision build, a derivative term. All gains are fixed at elaboration time as parameters. The sign is chosen so that a receiver clock running ahead of the reference time (positive bias) pulls the control word down, which slows the oscillator. A negative bias pushes the control word up.

A two-bit mode input picks what the loop regulates. In frequency acquisition the error is the change in bias since the previous epoch. During the phase-pull ramps the error is the distance between the measured bias and a moving setpoint. Once locked, the error is the bias itself. A hold input freezes the control word and the integrator while the time solution is unusable. The control word is registered and announced by a one-cycle strobe. Measuring the bias and driving the oscillator are handled elsewhere.

Top module: `osc_steer_filter`

## Requirements
- R1: During and after a synchronous active-low reset, `ctrl_word` is 0 and `ctrl_strobe` is 0. The integrator, the previous-bias history and the derivative history are all cleared (marked empty).
- R2: With `mode` 2 or `mode` 3 the error is the sign-extended `bias`.
- R3: With `mode` 0 the error is `bias` minus the `bias` of the previous epoch, whatever mode that epoch used. On the first epoch after reset the error is 0.
- R4: With `mode` 1 the error is `bias` minus `setpoint`.
- R5: An epoch that is not held produces ctrl_word = clamp(floor(-(KP*e + I + KD*d) / 2^OUT_SHIFT)). Here e is the error, I is the integrator value after this epoch's update, and d is the derivative difference. A positive error therefore lowers the word.
- R6: Each epoch that is not held adds KI*e to the integrator. The integrator saturates at +INT_LIM and -INT_LIM.
- R7: When DERIV_EN=1, d is e minus the error of the previous epoch, but only if the previous epoch used the same error source (modes 2 and 3 count as one source). Otherwise d is 0. When DERIV_EN=0 the derivative term is absent.
- R8: An epoch with `hold`=1 leaves `ctrl_word` and the integrator unchanged. It still advances the bias and derivative histories, and it still produces a strobe.
- R9: `epoch_valid` is sampled at clock edge k. `ctrl_word` changes at edge k+1, and `ctrl_strobe` is high for exactly the cycle that follows edge k+1.
- R10: The control word saturates at the signed CW-bit limits, -2^(CW-1) and 2^(CW-1)-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| epoch_valid | input | 1 | One-cycle pulse: a new measurement is present |
| mode | input | 2 | Error source: 0 bias change, 1 setpoint error, 2/3 raw bias |
| bias | input | EW | Signed clock bias of this epoch |
| setpoint | input | EW | Signed target bias used in mode 1 |
| hold | input | 1 | Freeze the output and the integrator for this epoch |
| ctrl_word | output | CW | Signed oscillator control word |
| ctrl_strobe | output | 1 | High for one cycle when the control word has been updated |

## Verification
The bench builds two copies of the filter with 8-bit bias and an 8-bit control word. The gains are KP=3, KI=1, KD=2, the integrator limit is 200 and the output shift is 1. One copy has the derivative term enabled and the other has it disabled. At these sizes a sweep of the bias through every one of its 256 codes drives the integrator into both of its limits and the output into both of its clamps within a few hundred epochs. Ramp and bias-change sweeps, hold epochs scattered through every sweep, and mode switches that clear the derivative history are then checked epoch by epoch against an integer model of the control law.

// File: rtl/steer_pkg.sv
// Package: shared types for the oscillator steering filter.
// Assumes: mode codes 2 and 3 both select the raw-bias source.
package steer_pkg;

    typedef enum logic [1:0] {
        SRC_DBIAS = 2'd0,
        SRC_RAMP  = 2'd1,
        SRC_BIAS  = 2'd2
    } err_src_e;

    // Map the external mode code onto an error source.
    function automatic err_src_e decode_mode(input logic [1:0] m);
        case (m)
            2'd0:    return SRC_DBIAS;
            2'd1:    return SRC_RAMP;
            default: return SRC_BIAS;
        endcase
    endfunction

endpackage

// File: rtl/steer_err_sel.sv
// Module: steer_err_sel
// Selects the loop error by mode and forms the derivative difference.
// Registers the epoch (error, derivative, hold) into a single stage.
// Assumes: epoch_valid is a one-cycle pulse; the histories advance on
// every epoch, held or not.
module steer_err_sel
    import steer_pkg::*;
#(
    parameter int EW       = 16,
    parameter bit DERIV_EN = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 epoch_valid,
    input  logic [1:0]           mode,
    input  logic signed [EW-1:0] bias,
    input  logic signed [EW-1:0] setpoint,
    input  logic                 hold,
    output logic                 stg_valid,
    output logic                 stg_hold,
    output logic signed [EW:0]   stg_err,
    output logic signed [EW+1:0] stg_der
);
    localparam int XW = EW + 1;
    localparam int DW = EW + 2;

    err_src_e            src;
    logic signed [XW-1:0] bias_x, sp_x, prev_x, err_now;
    logic signed [DW-1:0] der_now;
    logic signed [EW-1:0] prev_bias;
    logic                 pb_valid;

    assign src    = decode_mode(mode);
    assign bias_x = $signed({bias[EW-1], bias});
    assign sp_x   = $signed({setpoint[EW-1], setpoint});
    assign prev_x = $signed({prev_bias[EW-1], prev_bias});

    // Pick the error term for the selected source.
    always_comb begin
        case (src)
            SRC_DBIAS: err_now = pb_valid ? (bias_x - prev_x) : '0;
            SRC_RAMP:  err_now = bias_x - sp_x;
            default:   err_now = bias_x;
        endcase
    end

    // Keep the previous epoch's bias for the bias-change source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_bias <= '0;
            pb_valid  <= 1'b0;
        end else if (epoch_valid) begin
            prev_bias <= bias;
            pb_valid  <= 1'b1;
        end
    end

    generate
        if (DERIV_EN) begin : g_der
            logic signed [XW-1:0] e_hist;
            logic                 eh_valid;
            err_src_e             last_src;

            // Difference against the last error, only within one source.
            always_comb begin
                if (eh_valid && (src == last_src))
                    der_now = $signed({err_now[XW-1], err_now}) - $signed({e_hist[XW-1], e_hist});
                else
                    der_now = '0;
            end

            // Derivative history; a source change restarts it.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    e_hist   <= '0;
                    eh_valid <= 1'b0;
                    last_src <= SRC_BIAS;
                end else if (epoch_valid) begin
                    e_hist   <= err_now;
                    eh_valid <= 1'b1;
                    last_src <= src;
                end
            end

            // R7
            der_reset_on_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
                epoch_valid && (src != last_src) |=> stg_der == '0);
        end else begin : g_noder
            assign der_now = '0;
        end
    endgenerate

    // Stage register carrying one epoch to the integrator and output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_valid <= 1'b0;
            stg_hold  <= 1'b0;
            stg_err   <= '0;
            stg_der   <= '0;
        end else begin
            stg_valid <= epoch_valid;
            if (epoch_valid) begin
                stg_hold <= hold;
                stg_err  <= err_now;
                stg_der  <= der_now;
            end
        end
    end

    // R3
    first_dbias_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        epoch_valid && !pb_valid && (mode == 2'd0) |=> stg_err == '0);

endmodule

// File: rtl/steer_integ.sv
// Module: steer_integ
// Saturating integral accumulator of KI*error.
// Assumes: ACC_W is wide enough to hold KI*error plus INT_LIM with margin.
// The next value is exported so the output uses this epoch's update.
module steer_integ #(
    parameter int EW      = 16,
    parameter int ACC_W   = 32,
    parameter int KI      = 4,
    parameter int INT_LIM = 1 << 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    stg_valid,
    input  logic                    stg_hold,
    input  logic signed [EW:0]      stg_err,
    output logic signed [ACC_W-1:0] acc,
    output logic signed [ACC_W-1:0] acc_next
);
    localparam int PW = ACC_W + 1;
    localparam logic signed [PW-1:0] KI_P  = PW'(KI);
    localparam logic signed [PW-1:0] LIM_P = PW'(INT_LIM);

    logic signed [PW-1:0] ki_term, sum_w, sat_w;

    // Add the scaled error and saturate at the limits.
    always_comb begin
        ki_term = PW'(stg_err) * KI_P;
        sum_w   = PW'(acc) + ki_term;
        if (sum_w > LIM_P)
            sat_w = LIM_P;
        else if (sum_w < -LIM_P)
            sat_w = -LIM_P;
        else
            sat_w = sum_w;
        acc_next = ACC_W'(sat_w);
    end

    // Commit only on epochs that are not held.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc <= '0;
        else if (stg_valid && !stg_hold)
            acc <= acc_next;
    end

    // R6
    integ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (PW'(acc) <= LIM_P) && (PW'(acc) >= -LIM_P));

    // R8
    integ_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stg_valid && stg_hold |=> $stable(acc));

endmodule

// File: rtl/steer_out.sv
// Module: steer_out
// Sums the P, I and D terms, negates, scales, clamps and registers
// the control word, with a strobe.
// Assumes: the inputs are valid in the cycle stg_valid is high.
module steer_out #(
    parameter int EW        = 16,
    parameter int ACC_W     = 32,
    parameter int CW        = 16,
    parameter int KP        = 64,
    parameter int KD        = 32,
    parameter int OUT_SHIFT = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    stg_valid,
    input  logic                    stg_hold,
    input  logic signed [EW:0]      stg_err,
    input  logic signed [EW+1:0]    stg_der,
    input  logic signed [ACC_W-1:0] acc_next,
    output logic signed [CW-1:0]    ctrl_word,
    output logic                    ctrl_strobe
);
    localparam int SW = ACC_W + 2;
    localparam logic signed [SW-1:0] KP_S    = SW'(KP);
    localparam logic signed [SW-1:0] KD_S    = SW'(KD);
    localparam logic signed [SW-1:0] OUT_MAX = SW'((2 ** (CW - 1)) - 1);
    localparam logic signed [SW-1:0] OUT_MIN = -OUT_MAX - SW'(1);

    logic signed [SW-1:0] p_term, d_term, total, steer, scaled, clamped;

    // Form the steering value; positive error lowers the word.
    always_comb begin
        p_term = SW'(stg_err) * KP_S;
        d_term = SW'(stg_der) * KD_S;
        total  = p_term + SW'(acc_next) + d_term;
        steer  = -total;
        scaled = steer >>> OUT_SHIFT;
        if (scaled > OUT_MAX)
            clamped = OUT_MAX;
        else if (scaled < OUT_MIN)
            clamped = OUT_MIN;
        else
            clamped = scaled;
    end

    // Output register and update strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_word   <= '0;
            ctrl_strobe <= 1'b0;
        end else begin
            ctrl_strobe <= stg_valid;
            if (stg_valid && !stg_hold)
                ctrl_word <= CW'(clamped);
        end
    end

    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stg_valid && stg_hold |=> $stable(ctrl_word));

    // R9
    out_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stg_valid |=> $stable(ctrl_word) && !ctrl_strobe);

endmodule

// File: rtl/osc_steer_filter.sv
// Module: osc_steer_filter (top)
// Per-epoch PI or PID loop filter that steers an oscillator control word.
// Assumes: epoch_valid pulses for one cycle per measurement; gains are
// non-negative and the widths are large enough to hold their products.
module osc_steer_filter #(
    parameter int EW        = 16,
    parameter int CW        = 16,
    parameter int ACC_W     = 32,
    parameter int KP        = 64,
    parameter int KI        = 4,
    parameter int KD        = 32,
    parameter int INT_LIM   = 1 << 24,
    parameter int OUT_SHIFT = 4,
    parameter bit DERIV_EN  = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 epoch_valid,
    input  logic [1:0]           mode,
    input  logic signed [EW-1:0] bias,
    input  logic signed [EW-1:0] setpoint,
    input  logic                 hold,
    output logic signed [CW-1:0] ctrl_word,
    output logic                 ctrl_strobe
);
    logic                    stg_valid, stg_hold;
    logic signed [EW:0]      stg_err;
    logic signed [EW+1:0]    stg_der;
    logic signed [ACC_W-1:0] acc, acc_next;

    steer_err_sel #(.EW(EW), .DERIV_EN(DERIV_EN)) u_err (
        .clk(clk), .rst_n(rst_n), .epoch_valid(epoch_valid), .mode(mode),
        .bias(bias), .setpoint(setpoint), .hold(hold),
        .stg_valid(stg_valid), .stg_hold(stg_hold),
        .stg_err(stg_err), .stg_der(stg_der)
    );

    steer_integ #(.EW(EW), .ACC_W(ACC_W), .KI(KI), .INT_LIM(INT_LIM)) u_int (
        .clk(clk), .rst_n(rst_n), .stg_valid(stg_valid), .stg_hold(stg_hold),
        .stg_err(stg_err), .acc(acc), .acc_next(acc_next)
    );

    steer_out #(.EW(EW), .ACC_W(ACC_W), .CW(CW), .KP(KP), .KD(KD),
                .OUT_SHIFT(OUT_SHIFT)) u_out (
        .clk(clk), .rst_n(rst_n), .stg_valid(stg_valid), .stg_hold(stg_hold),
        .stg_err(stg_err), .stg_der(stg_der), .acc_next(acc_next),
        .ctrl_word(ctrl_word), .ctrl_strobe(ctrl_strobe)
    );

    // R9
    epoch_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        epoch_valid |=> ##1 ctrl_strobe);

    // R9
    strobe_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_strobe |-> $past(epoch_valid, 2));

    // R1
    reset_out_chk: assert property (@(posedge clk)
        !rst_n |=> (ctrl_word == '0) && !ctrl_strobe);

endmodule

// File: tb/tb_osc_steer_filter.sv
// Bench: sweeps a small build of the filter, with and without the
// derivative term, against an integer model of the control law.
module tb_osc_steer_filter;
    localparam int EW = 8, CW = 8, KP = 3, KI = 1, KD = 2, LIM = 200, SH = 1;

    logic clk = 1'b0, rst_n = 1'b0, epoch_valid = 1'b0, hold = 1'b0;
    logic [1:0] mode = 2'd2;
    logic signed [EW-1:0] bias = '0, setpoint = '0;
    logic signed [CW-1:0] cw_d, cw_p;
    logic st_d, st_p;

    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;

    // model state
    int m_prev, m_eprev, m_src_last, m_acc, m_out_d, m_out_p;
    bit m_pb_v, m_eh_v;

    always #5 clk = ~clk;

    osc_steer_filter #(.EW(EW), .CW(CW), .ACC_W(16), .KP(KP), .KI(KI), .KD(KD),
        .INT_LIM(LIM), .OUT_SHIFT(SH), .DERIV_EN(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .epoch_valid(epoch_valid), .mode(mode),
        .bias(bias), .setpoint(setpoint), .hold(hold),
        .ctrl_word(cw_d), .ctrl_strobe(st_d));

    osc_steer_filter #(.EW(EW), .CW(CW), .ACC_W(16), .KP(KP), .KI(KI), .KD(KD),
        .INT_LIM(LIM), .OUT_SHIFT(SH), .DERIV_EN(1'b0)) dut_pi (
        .clk(clk), .rst_n(rst_n), .epoch_valid(epoch_valid), .mode(mode),
        .bias(bias), .setpoint(setpoint), .hold(hold),
        .ctrl_word(cw_p), .ctrl_strobe(st_p));

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int law(input int e, input int acc, input int d);
        int s;
        s = -(KP * e + acc + KD * d);
        s = s >>> SH;
        if (s > 127) s = 127;
        if (s < -128) s = -128;
        return s;
    endfunction

    task automatic model_reset();
        m_prev = 0; m_eprev = 0; m_src_last = 2; m_acc = 0;
        m_out_d = 0; m_out_p = 0; m_pb_v = 0; m_eh_v = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; epoch_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        // R1
        chk("R1 word", int'(cw_d), 0);
        chk("R1 strobe", int'(st_d), 0);
        chk("R1 word pi", int'(cw_p), 0);
        rst_n = 1'b1;
        model_reset();
    endtask

    // One epoch: drive, advance the model, check at the update cycle.
    task automatic epoch(input int md, input int b, input int sp, input bit h, input string base);
        int src, e, d;
        string tag;
        src = (md >= 2) ? 2 : md;
        e = (src == 0) ? (m_pb_v ? b - m_prev : 0) : (src == 1) ? b - sp : b;
        d = (m_eh_v && src == m_src_last) ? e - m_eprev : 0;
        m_prev = b; m_pb_v = 1; m_eprev = e; m_eh_v = 1; m_src_last = src;
        if (!h) begin
            m_acc = m_acc + KI * e;
            if (m_acc > LIM) m_acc = LIM;
            if (m_acc < -LIM) m_acc = -LIM;
            m_out_d = law(e, m_acc, d);
            m_out_p = law(e, m_acc, 0);
        end
        if (base != "") tag = base;
        else if (h) tag = "R8";
        else if (m_out_d == 127 || m_out_d == -128) tag = "R10";
        else if (m_acc == LIM || m_acc == -LIM) tag = "R6";
        else tag = (src == 0) ? "R3" : (src == 1) ? "R4" : "R2";
        @(negedge clk);
        mode = 2'(md); bias = EW'(b); setpoint = EW'(sp); hold = h; epoch_valid = 1'b1;
        @(negedge clk);
        epoch_valid = 1'b0;
        chk("R9 strobe early", int'(st_d), 0);
        @(negedge clk);
        chk("R9 strobe", int'(st_d), 1);
        chk(tag, int'(cw_d), m_out_d);
        chk("R7 no-derivative build", int'(cw_p), m_out_p);
    endtask

    initial begin
        model_reset();
        do_reset();
        // R3: first bias-change epoch after reset has zero error
        epoch(0, 50, 0, 1'b0, "R3 first");
        // R5: small-signal, unclamped responses
        do_reset();
        for (int i = 0; i < 40; i++) epoch(2, (i % 11) - 5, 0, 1'b0, "R5");
        // R2/R6/R10: full bias sweep up then down, holds sprinkled (R8)
        for (int i = -128; i < 128; i++) epoch(2, i, 0, (i % 9) == 4, "");
        for (int i = 127; i >= -128; i -= 3) epoch(2, i, 0, (i % 7) == 2, "");
        // R2: mode 3 behaves as raw bias, no history reset vs mode 2
        for (int i = 0; i < 10; i++) epoch(3, 40 - 9 * i, 0, 1'b0, "R2 mode3");
        // R4: ramp errors
        do_reset();
        for (int i = -128; i < 128; i += 5) epoch(1, i, ((i * 3) % 101) - 20, (i % 4) == 1, "");
        // R3: bias-change sweep
        for (int i = 0; i < 60; i++) epoch(0, ((i * i) % 256) - 128, 0, (i % 10) == 7, "");
        // R7: source switches every epoch
        do_reset();
        for (int i = 0; i < 30; i++) epoch(i % 3, (i * 17) % 61 - 30, i - 15, 1'b0, "R7 switch");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule